// File: doc/BRIEF.md
# Per-Channel PWM Pin Delay

This block sits between a seven-channel timer array and the package pins. For every channel it can hold back the timer output by zero to three cycles of the system clock before that output reaches the pin. The idea is to stagger edges on several PWM pins that would otherwise switch in the same cycle. A copy of each raw timer output is also handed to internal peripherals, and that copy is never delayed.

The delay codes live in one 16-bit control word, written over a simple peripheral bus with two byte strobes. The word only changes on a write that enables both byte lanes. Each pin also has a function select: the delayed timer value reaches the pin only when the select picks the timer function. Otherwise the pin carries an alternate signal, and the delay setting has no effect on it. Software should only rewrite the word while PWM is stopped, and only after waiting four clocks so the delay stages have emptied.

Top module: `pwm_pin_delay`

## Requirements
- R1: A channel whose code is 00 drives its timer input to `pin_out` in the same cycle, with no register in between.
- R2: Code 01 delays a channel's pin output by exactly one clock cycle, code 10 by two and code 11 by three, so `pin_out` equals the timer input from that many cycles earlier.
- R3: Input bit k (k = 0..6) belongs to channel k+1 and is controlled by control-word bits [2k+3:2k+2]. Bits [1:0] are reserved and always read back as 0, whatever value was written there.
- R4: After reset the control word reads 0x0000, every channel is undelayed, and all delay stages hold 0.
- R5: A write with `bus_wr` = 1 and `bus_be` = 2'b11 loads `bus_wdata` into the control word at the next clock edge. `bus_rdata` then shows that value with bits [1:0] cleared.
- R6: A write with `bus_be` of 2'b01, 2'b10 or 2'b00 leaves the control word unchanged and leaves the pin delays unchanged.
- R7: `int_out` always equals `tmr_in` in the same cycle, whatever the delay codes are.
- R8: When `pin_fn_tmr[k]` is 0, `pin_out[k]` equals `alt_in[k]` and ignores the timer path. When it is 1, `pin_out[k]` carries the timer path with its delay applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write request for the control word |
| bus_be | input | 2 | Byte-lane enables; bit 0 covers bits [7:0] |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Current control word, reserved bits read as 0 |
| tmr_in | input | 7 | Raw timer outputs; bit k is channel k+1 |
| pin_fn_tmr | input | 7 | Per-pin select: 1 chooses the timer function |
| alt_in | input | 7 | Alternate pin function values |
| pin_out | output | 7 | Signals driven to the pins |
| int_out | output | 7 | Undelayed timer outputs for internal peripherals |

## Verification
Random PWM bit streams run with all channels set to the same code, once for each of the four codes. Because the inputs change every cycle, these runs tell an off-by-one delay apart from the correct one and a registered zero-delay path apart from a combinational one. A control word with a different code on each channel then checks that each field reaches its own channel and not a neighbour. Partial-strobe writes of conflicting data are followed by further traffic, to show that neither the read value nor the pin timing moved. Phases with the function select cleared, running under non-zero codes, show that the alternate value passes straight through while `int_out` still tracks the raw input.

// File: rtl/pwm_pin_delay.sv
module pwm_pin_delay #(
  parameter int NCH  = 7,
  parameter int MAXD = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [1:0]                bus_be,
  input  logic [15:0]               bus_wdata,
  output logic [15:0]               bus_rdata,
  input  logic [NCH-1:0]            tmr_in,
  input  logic [NCH-1:0]            pin_fn_tmr,
  input  logic [NCH-1:0]            alt_in,
  output logic [NCH-1:0]            pin_out,
  output logic [NCH-1:0]            int_out
);
  localparam int FW = $clog2(MAXD + 1);
  localparam int RW = FW * (NCH + 1);
  localparam logic [RW-1:0] WMASK = {{(RW-FW){1'b1}}, {FW{1'b0}}};

  logic [RW-1:0] ctl_q;
  logic [NCH-1:0] dly;
  logic full_wr;

  assign full_wr = bus_wr && (&bus_be);

  always_ff @(posedge clk) begin
    if (!rst_n)       ctl_q <= '0;
    else if (full_wr) ctl_q <= bus_wdata & WMASK;
  end

  assign bus_rdata = ctl_q;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [MAXD-1:0] stg;
    logic [MAXD:0]   tap;
    logic [FW-1:0]   code;

    assign tap  = {stg, tmr_in[k]};
    assign code = ctl_q[FW*(k+1) +: FW];

    always_ff @(posedge clk) begin
      if (!rst_n) stg <= '0;
      else        stg <= tap[MAXD-1:0];
    end

    assign dly[k]     = tap[code];
    assign pin_out[k] = pin_fn_tmr[k] ? dly[k] : alt_in[k];
  end

  assign int_out = tmr_in;
endmodule

module pwm_pin_delay_chk #(
  parameter int NCH  = 7,
  parameter int MAXD = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [1:0]      bus_be,
  input logic [15:0]     bus_wdata,
  input logic [15:0]     bus_rdata,
  input logic [NCH-1:0]  tmr_in,
  input logic [NCH-1:0]  pin_fn_tmr,
  input logic [NCH-1:0]  pin_out
);
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[1:0] == 2'b00);

  assert_full_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_be == 2'b11) |=> bus_rdata == {$past(bus_wdata[15:2]), 2'b00});

  assert_partial_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_be != 2'b11) |=> $stable(bus_rdata));

  for (genvar k = 0; k < NCH; k++) begin : g_a
    assert_zero_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_fn_tmr[k] && bus_rdata[2*k+3 -: 2] == 2'd0) |-> pin_out[k] == tmr_in[k]);

    assert_one_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_fn_tmr[k] && bus_rdata[2*k+3 -: 2] == 2'd1) |-> pin_out[k] == $past(tmr_in[k]));
  end
endmodule

bind pwm_pin_delay pwm_pin_delay_chk #(.NCH(NCH), .MAXD(MAXD)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_be(bus_be),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_in(tmr_in),
  .pin_fn_tmr(pin_fn_tmr), .pin_out(pin_out)
);

// File: tb/pwm_pin_delay_tb_top.sv
module pwm_pin_delay_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [1:0]  bus_be = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic [6:0]  tmr_in = 0, pin_fn_tmr = 0, alt_in = 0, pin_out, int_out;

  int checks = 0, errors = 0;
  logic [15:0] m_ctl = 0;
  logic [6:0]  hist [1:3];
  logic [6:0]  q_pin[$], q_int[$];
  logic [15:0] q_rd[$];
  string       q_tag[$];
  bit          done = 0;

  always #5 clk = ~clk;

  pwm_pin_delay dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_in(tmr_in),
    .pin_fn_tmr(pin_fn_tmr), .alt_in(alt_in), .pin_out(pin_out), .int_out(int_out)
  );

  task automatic drive(input logic [6:0] tin, input logic [6:0] sel, input logic [6:0] alt,
                       input logic wr, input logic [1:0] be, input logic [15:0] wd,
                       input string tag);
    logic [6:0] exp;
    @(negedge clk);
    tmr_in = tin; pin_fn_tmr = sel; alt_in = alt;
    bus_wr = wr; bus_be = be; bus_wdata = wd;
    for (int k = 0; k < 7; k++) begin
      int c;
      c = m_ctl[2*k+2 +: 2];
      if (!sel[k])    exp[k] = alt[k];
      else if (c == 0) exp[k] = tin[k];
      else             exp[k] = hist[c][k];
    end
    q_pin.push_back(exp); q_int.push_back(tin); q_rd.push_back(m_ctl); q_tag.push_back(tag);
    hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = tin;
    if (wr && be == 2'b11) m_ctl = {wd[15:2], 2'b00};
  endtask

  task automatic run(input int n, input logic [6:0] sel, input string tag);
    for (int i = 0; i < n; i++)
      drive(7'($urandom), sel, 7'($urandom), 1'b0, 2'b00, 16'h0, tag);
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] wd, input string tag);
    drive(7'($urandom), 7'h7f, 7'($urandom), 1'b1, be, wd, tag);
  endtask

  initial begin
    forever begin
      @(negedge clk); #2;
      if (q_pin.size() > 0) begin
        logic [6:0] ep, ei; logic [15:0] er; string t;
        ep = q_pin.pop_front(); ei = q_int.pop_front(); er = q_rd.pop_front(); t = q_tag.pop_front();
        checks++;
        if (pin_out !== ep) begin errors++; $display("FAIL %s pin_out act=%h exp=%h", t, pin_out, ep); end
        checks++;
        if (int_out !== ei) begin errors++; $display("FAIL R7 int_out act=%h exp=%h", int_out, ei); end
        checks++;
        if (bus_rdata !== er) begin errors++; $display("FAIL %s bus_rdata act=%h exp=%h", t, bus_rdata, er); end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    hist[1] = 0; hist[2] = 0; hist[3] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    run(10, 7'h7f, "R4");
    for (int c = 0; c < 4; c++) begin
      logic [15:0] w;
      w = {7{2'(c)}} << 2;
      wr(2'b11, w, "R5");
      run(4, 7'h7f, "R5");
      run(40, 7'h7f, (c == 0) ? "R1" : "R2");
    end
    wr(2'b11, 16'b11_10_01_00_11_10_01_11, "R3");
    run(60, 7'h7f, "R3");
    run(30, 7'h55, "R8");
    run(20, 7'h00, "R8");
    wr(2'b01, 16'h0000, "R6");
    run(3, 7'h7f, "R6");
    wr(2'b10, 16'hffff, "R6");
    run(3, 7'h7f, "R6");
    wr(2'b00, 16'h5a5a, "R6");
    run(30, 7'h7f, "R6");
    wr(2'b11, 16'h9c6b, "R5");
    run(40, 7'h2b, "R2");
    while (q_pin.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule